// File: doc/BRIEF.md
# Short Packet Capture Queue

This block holds the generic short packets that a camera serial receiver decodes, until software collects them. Each packet arrives as a single-cycle valid pulse. The pulse carries a 6-bit data type, a 2-bit virtual channel and a 16-bit data value. The packet goes into a first-in first-out store of 31 entries.

Software reads the oldest packet as one 32-bit word. A read strobe removes that packet from the store in the same access. The word shows the head entry combinationally, so the value read is the value that gets removed.

The block drives four flags for the surrounding status and interrupt logic:
- full, as a status level;
- not-empty, as a status level;
- a sticky overflow interrupt bit;
- a not-empty interrupt bit that re-arms itself after a write-1 clear while packets remain. Software can therefore drain the queue by repeating a read followed by a clear.

A soft clear empties the queue and drops both interrupt bits.

Top module: `spkt_capture_fifo`

## Requirements
- R1: After reset the queue is empty, `rd_word` is 0, and `sts_full`, `sts_nempty`, `irq_nempty` and `irq_ovf` are all 0.
- R2: The read word packs the stored packet as follows: data value in bits 23:8, virtual channel in bits 7:6, data type in bits 5:0. Bits 31:24 are always 0.
- R3: `rd_word` always shows the oldest stored packet. Each `rd_pop` cycle with a non-empty queue removes exactly that packet, so packets leave in arrival order.
- R4: The queue holds up to `DEPTH` (31) packets. `sts_full` is 1 exactly when 31 packets are stored.
- R5: A packet that arrives while the queue is full, with no pop in the same cycle, is dropped and sets `irq_ovf` on the next edge. `irq_ovf` stays set until an `irq_clr_ovf` pulse. If a drop and a clear fall in the same cycle, the set wins.
- R6: While the queue is empty, `rd_word` reads 0 and `rd_pop` changes nothing.
- R7: A packet arriving in the same cycle as a pop on a full queue is accepted. The queue stays full and the new packet takes the tail position.
- R8: `sts_nempty` is 1 exactly when at least one packet is stored.
- R9: The following cycle-level rules govern `irq_nempty`:
  - An accepted packet sets it on the next edge.
  - An `irq_clr_ne` pulse clears it on the next edge; the clear wins over a same-cycle set.
  - On any later edge it sets again if the queue held packets before that edge.
  - After the queue drains, it stays set until cleared.
- R10: A `soft_clr` cycle empties the queue, clears both interrupt bits, and discards any packet or pop presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of queue and interrupt bits |
| pkt_valid | input | 1 | Short packet present this cycle |
| pkt_dtype | input | 6 | Packet data type |
| pkt_vchan | input | 2 | Packet virtual channel |
| pkt_data | input | 16 | Packet data value |
| rd_pop | input | 1 | Read strobe of the packet word; removes the head |
| irq_clr_ne | input | 1 | Write-1 clear of the not-empty interrupt bit |
| irq_clr_ovf | input | 1 | Write-1 clear of the overflow interrupt bit |
| rd_word | output | 32 | Oldest packet, packed; 0 when empty |
| sts_full | output | 1 | Queue holds 31 packets |
| sts_nempty | output | 1 | Queue holds at least one packet |
| irq_nempty | output | 1 | Self re-arming not-empty interrupt bit |
| irq_ovf | output | 1 | Sticky overflow interrupt bit |

## Verification
Two pairs of functions can fall in the same cycle:
- a packet arrival and a pop on a full queue;
- an interrupt clear and the event that sets the same bit (a drop or a re-arm).

Directed steps fill the queue to 31 entries and then:
- push and pop together at the boundary;
- push alone, to force a drop;
- clear the not-empty bit while entries remain.

A seeded random phase then mixes arrivals, pops, clears and rare soft clears. After every edge, the bench compares each output against a queue model kept in the bench.

// File: rtl/spkt_pkg.sv
package spkt_pkg;
  localparam int unsigned DT_W    = 6;
  localparam int unsigned VC_W    = 2;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ENTRY_W = DATA_W + VC_W + DT_W;
  localparam int unsigned WORD_W  = 32;

  // Packed layout sets the read-word bit positions: data high, type low.
  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [VC_W-1:0]   vc;
    logic [DT_W-1:0]   dt;
  } spkt_entry_t;

  function automatic logic [WORD_W-1:0] spkt_word(input spkt_entry_t e);
    return {{(WORD_W-ENTRY_W){1'b0}}, e};
  endfunction
endpackage

// File: rtl/spkt_occupancy.sv
module spkt_occupancy #(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             nempty
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic             upd_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt_q == CNT_MAX);
    nempty  = (cnt_q != '0);
    pop_ok  = pop_req && nempty && !soft_clr;
    push_ok = push_req && !soft_clr && (!full || pop_ok);
    drop    = push_req && !soft_clr && full && !pop_ok;
  end

  always_comb begin
    cnt_d = cnt_q;
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (soft_clr) begin
      cnt_d = '0;
      wp_d  = '0;
      rp_d  = '0;
    end else begin
      if (push_ok) wp_d = ptr_inc(wp_q);
      if (pop_ok)  rp_d = ptr_inc(rp_q);
      if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    end
  end

  assign upd_en = soft_clr || push_ok || pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      wp_q  <= wp_d;
      rp_q  <= rp_d;
    end
  end

  assign wr_ptr = wp_q;
  assign rd_ptr = rp_q;
endmodule

// File: rtl/spkt_store.sv
module spkt_store
  import spkt_pkg::*;
#(
  parameter int unsigned DEPTH = 31,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  spkt_entry_t      wr_entry,
  input  logic [PTR_W-1:0] rd_ptr,
  output spkt_entry_t      rd_entry
);
  spkt_entry_t slot_q [DEPTH];

  // Data slots carry no reset; the top gates the read word while empty.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_entry;
    end
  end

  assign rd_entry = slot_q[rd_ptr];
endmodule

// File: rtl/spkt_irq_flags.sv
module spkt_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic push_ok,
  input  logic drop,
  input  logic held_any,
  input  logic clr_ne,
  input  logic clr_ovf,
  output logic irq_ne,
  output logic irq_ov
);
  logic ne_q, ne_d, ov_q, ov_d;

  always_comb begin
    ne_d = ne_q;
    ov_d = ov_q;
    if (soft_clr) begin
      ne_d = 1'b0;
      ov_d = 1'b0;
    end else begin
      // Clear wins this edge; re-arm follows on the next while entries remain.
      if (clr_ne)                   ne_d = 1'b0;
      else if (push_ok || held_any) ne_d = 1'b1;
      // A same-cycle drop beats the clear so no overflow goes unseen.
      if (drop)         ov_d = 1'b1;
      else if (clr_ovf) ov_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q <= 1'b0;
      ov_q <= 1'b0;
    end else begin
      ne_q <= ne_d;
      ov_q <= ov_d;
    end
  end

  assign irq_ne = ne_q;
  assign irq_ov = ov_q;
endmodule

// File: rtl/spkt_capture_fifo.sv
module spkt_capture_fifo
  import spkt_pkg::*;
#(
  parameter int unsigned DEPTH = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              pkt_valid,
  input  logic [DT_W-1:0]   pkt_dtype,
  input  logic [VC_W-1:0]   pkt_vchan,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              rd_pop,
  input  logic              irq_clr_ne,
  input  logic              irq_clr_ovf,
  output logic [WORD_W-1:0] rd_word,
  output logic              sts_full,
  output logic              sts_nempty,
  output logic              irq_nempty,
  output logic              irq_ovf
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             push_ok, pop_ok, drop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  spkt_entry_t      in_entry, head_entry;

  assign in_entry = '{data: pkt_data, vc: pkt_vchan, dt: pkt_dtype};

  spkt_occupancy #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .push_req (pkt_valid),
    .pop_req  (rd_pop),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .drop     (drop),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .full     (sts_full),
    .nempty   (sts_nempty)
  );

  spkt_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .wr_en    (push_ok),
    .wr_ptr   (wr_ptr),
    .wr_entry (in_entry),
    .rd_ptr   (rd_ptr),
    .rd_entry (head_entry)
  );

  spkt_irq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .push_ok  (push_ok),
    .drop     (drop),
    .held_any (sts_nempty),
    .clr_ne   (irq_clr_ne),
    .clr_ovf  (irq_clr_ovf),
    .irq_ne   (irq_nempty),
    .irq_ov   (irq_ovf)
  );

  assign rd_word = sts_nempty ? spkt_word(head_entry) : '0;
endmodule

// File: rtl/spkt_capture_fifo_checker.sv
module spkt_capture_fifo_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_clr,
  input logic        pkt_valid,
  input logic        rd_pop,
  input logic        irq_clr_ne,
  input logic [31:0] rd_word,
  input logic        sts_full,
  input logic        sts_nempty,
  input logic        irq_nempty,
  input logic        irq_ovf
);
  a_r2_top_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[31:24] == 8'h00);

  a_r4_full_implies_held: assert property (@(posedge clk) disable iff (!rst_n)
    sts_full |-> sts_nempty);

  a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && sts_full && !rd_pop && !soft_clr) |=> irq_ovf);

  a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_nempty |-> (rd_word == 32'h0));

  a_r7_full_swap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_full && pkt_valid && rd_pop && !soft_clr) |=> sts_full);

  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_nempty && !irq_nempty && !irq_clr_ne && !soft_clr) |=> irq_nempty);

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!sts_nempty && !irq_nempty && !irq_ovf));
endmodule

bind spkt_capture_fifo spkt_capture_fifo_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_clr   (soft_clr),
  .pkt_valid  (pkt_valid),
  .rd_pop     (rd_pop),
  .irq_clr_ne (irq_clr_ne),
  .rd_word    (rd_word),
  .sts_full   (sts_full),
  .sts_nempty (sts_nempty),
  .irq_nempty (irq_nempty),
  .irq_ovf    (irq_ovf)
);

// File: tb/spkt_capture_fifo_bench.sv
module spkt_capture_fifo_bench;
  localparam int DEPTH = 31;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_clr, pkt_valid, rd_pop, irq_clr_ne, irq_clr_ovf;
  logic [5:0]  pkt_dtype;
  logic [1:0]  pkt_vchan;
  logic [15:0] pkt_data;
  logic [31:0] rd_word;
  logic        sts_full, sts_nempty, irq_nempty, irq_ovf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [23:0] mq[$];
  bit m_ne, m_ov;

  always #4 clk = ~clk;

  spkt_capture_fifo u_spkt_capture_fifo (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .pkt_valid(pkt_valid),
    .pkt_dtype(pkt_dtype), .pkt_vchan(pkt_vchan), .pkt_data(pkt_data),
    .rd_pop(rd_pop), .irq_clr_ne(irq_clr_ne), .irq_clr_ovf(irq_clr_ovf),
    .rd_word(rd_word), .sts_full(sts_full), .sts_nempty(sts_nempty),
    .irq_nempty(irq_nempty), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return (mq.size() != 0) ? {8'h00, mq[0]} : 32'h0;
  endfunction

  // Called at a negedge; returns at the following negedge after checks.
  task automatic cyc(input bit v, input logic [5:0] dt, input logic [1:0] vc,
                     input logic [15:0] d, input bit pop, input bit cne,
                     input bit cov, input bit sc);
    int  sz;
    bit  full, pop_ok, push_ok, drop;
    pkt_valid = v; pkt_dtype = dt; pkt_vchan = vc; pkt_data = d;
    rd_pop = pop; irq_clr_ne = cne; irq_clr_ovf = cov; soft_clr = sc;
    #1;
    if (mq.size() != 0) chk("R3 head word", rd_word, exp_word());
    else                chk("R6 empty word", rd_word, 32'h0);
    chk("R2 top byte", {24'h0, rd_word[31:24]}, 32'h0);
    sz = mq.size();
    full = (sz == DEPTH);
    if (sc) begin
      mq.delete(); m_ne = 0; m_ov = 0;
    end else begin
      pop_ok  = pop && sz != 0;
      push_ok = v && (!full || pop_ok);
      drop    = v && full && !pop_ok;
      if (cne) m_ne = 0; else if (push_ok || sz != 0) m_ne = 1;
      if (drop) m_ov = 1; else if (cov) m_ov = 0;
      if (pop_ok) void'(mq.pop_front());
      if (push_ok) mq.push_back({d, vc, dt});
    end
    @(posedge clk);
    @(negedge clk);
    chk("R4 full", {31'h0, sts_full}, {31'h0, mq.size() == DEPTH});
    chk("R8 not empty", {31'h0, sts_nempty}, {31'h0, mq.size() != 0});
    chk("R9 ne irq", {31'h0, irq_nempty}, {31'h0, m_ne});
    chk("R5 ovf irq", {31'h0, irq_ovf}, {31'h0, m_ov});
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; soft_clr = 0; pkt_valid = 0; rd_pop = 0;
    irq_clr_ne = 0; irq_clr_ovf = 0; pkt_dtype = 0; pkt_vchan = 0; pkt_data = 0;
    m_ne = 0; m_ov = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 word", rd_word, 32'h0);
    chk("R1 flags", {28'h0, sts_full, sts_nempty, irq_nempty, irq_ovf}, 32'h0);

    // R2 field placement with a directed pattern
    cyc(1, 6'h2A, 2'd3, 16'hBEEF, 0, 0, 0, 0);
    #1 chk("R2 packing", rd_word, 32'h00BEEFEA);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);

    // R6 pops on empty queue change nothing
    cyc(0, 0, 0, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0);

    // R4 fill to capacity
    for (int i = 0; i < DEPTH; i++) cyc(1, 6'(i), 2'(i), 16'(i * 257), 0, 0, 0, 0);
    chk("R4 full at 31", {31'h0, sts_full}, 32'h1);
    // R5 drop while full, then drop together with clear: set wins
    cyc(1, 6'h11, 2'd1, 16'hDEAD, 0, 0, 0, 0);
    cyc(1, 6'h12, 2'd2, 16'hDEAF, 0, 0, 1, 0);
    chk("R5 set beats clear", {31'h0, irq_ovf}, 32'h1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    // R7 push and pop together at full
    cyc(1, 6'h3F, 2'd2, 16'hCAFE, 1, 0, 0, 0);
    chk("R7 still full", {31'h0, sts_full}, 32'h1);
    chk("R7 no overflow", {31'h0, irq_ovf}, 32'h0);
    // R9 clear while entries remain, then re-arm
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9 cleared", {31'h0, irq_nempty}, 32'h0);
    idle();
    chk("R9 re-armed", {31'h0, irq_nempty}, 32'h1);
    // drain with read-then-clear, plus extra empty reads
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 0, 0, 1, 1, 0, 0);
    idle();
    // R10 soft clear discards same-cycle push
    for (int i = 0; i < 5; i++) cyc(1, 6'(i + 7), 2'd0, 16'(i), 0, 0, 0, 0);
    cyc(1, 6'h05, 2'd1, 16'h1234, 1, 0, 0, 1);
    chk("R10 emptied", {31'h0, sts_nempty}, 32'h0);
    chk("R10 irq cleared", {30'h0, irq_nempty, irq_ovf}, 32'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit v, p, cn, co, s;
      v  = ($urandom_range(0, 99) < 55);
      p  = ($urandom_range(0, 99) < (i % 400 < 200 ? 30 : 60));
      cn = ($urandom_range(0, 99) < 10);
      co = ($urandom_range(0, 99) < 5);
      s  = ($urandom_range(0, 299) == 0);
      cyc(v, 6'($urandom), 2'($urandom), 16'($urandom), p, cn, co, s);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule